// File: doc/BRIEF.md
# Dual-Register Keystream Generator with Initialization

This block is a bit-serial pre-output generator. It has two 128-bit shift registers. One has linear feedback and the other has nonlinear feedback. A nonlinear filter combines taps from both registers into one pre-output bit per step. A start strobe loads a 128-bit key and a 96-bit nonce. The block then runs 384 initialization steps on its own, one per clock. Only after these steps does it offer keystream.

The initialization has three parts: a load, a mixing window and a key re-injection window. The mixing window is 256 steps long, and the pre-output bit is fed back into both registers. The re-injection window is 128 steps long, and the stored key is shifted serially into the linear feedback. During re-injection a phase flag is high, so that a downstream authenticator can capture those pre-output bits. After initialization the block raises `ready`. Each clock with `enable` high then yields one valid pre-output bit and advances both registers.

A new start strobe is accepted at any time. It abandons the current run and reloads the key and nonce.

Top module: `ksgen_top`

## Requirements
- R1: On a start strobe, nonlinear register bit i takes key bit i (i = 0..127). Linear register bits 0..95 take nonce bits 0..95, bits 96..126 become one, and bit 127 becomes zero.
- R2: On every step, each register moves bit i+1 into bit i. The linear register's new bit 127 is s0^s7^s38^s70^s81^s96, plus any phase-specific term.
- R3: The nonlinear register's new bit 127 is s0^b0^b26^b56^b91^b96^b3b67^b11b13^b17b18^b27b59^b40b48^b61b65^b68b84^b22b24b25^b70b78b82^b88b92b93b95, plus any phase-specific term.
- R4: `bitOut` always shows the pre-output bit of the current state: b12s8 ^ s13s20 ^ b95s42 ^ s60s79 ^ b12b95s94 ^ s93 ^ b2^b15^b36^b45^b64^b73^b89.
- R5: For the 256 steps that follow the load, the pre-output bit is XORed into both new bits. During these steps `ready`, `authPhase` and `bitValid` stay low, whatever `enable` does.
- R6: For steps 256..383, key bit (step−256) is XORed into the linear register's new bit, so key bit 0 goes first. The nonlinear register uses its plain feedback, and the pre-output bit is not fed back. `authPhase` is high for exactly these 128 steps.
- R7: After step 383, `ready` goes high and stays high until the next start. While ready, a clock with `enable` high shows `bitValid` high and advances the registers. A clock with `enable` low shows `bitValid` low and leaves the state, and so `bitOut`, unchanged.
- R8: A start strobe in any phase restarts the sequence from R1 with the key and nonce presented with it. `ready` and `authPhase` are low on the next cycle.
- R9: After reset, `ready`, `authPhase` and `bitValid` are low and both registers hold zero, so `bitOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load key and nonce and begin initialization |
| keyIn | input | 128 | Key, bit i goes to nonlinear register bit i |
| nonceIn | input | 96 | Nonce, bit i goes to linear register bit i |
| enable | input | 1 | Request one keystream bit once ready |
| bitOut | output | 1 | Pre-output bit of the current state |
| bitValid | output | 1 | bitOut is a keystream bit consumed this clock |
| ready | output | 1 | Initialization complete |
| authPhase | output | 1 | Current step belongs to the key re-injection window |

## Verification
The embedded assertions check several properties on every cycle. They check the constant load pattern in the top of the linear register. They check that the registers are frozen while idle or while `enable` is low in the ready state. They check that the phase flag and `ready` never overlap, that `ready` follows directly from the last re-injection step, and that a start always clears both flags. The exact bit values cannot be seen by a per-cycle property: the tap sets, the filter, the feedback of the pre-output during mixing and the order of key injection. Only the bench shows these, by comparing all 384 initialization bits and the following keystream with its own model, for fixed, random and aborted runs.

// File: rtl/ksgen_pkg.sv
package ksgen_pkg;

  localparam int REG_W     = 128;
  localparam int NONCE_W   = 96;
  localparam int MIX_STEPS = 256;
  localparam int KEY_STEPS = 128;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_MIX   = 2'd1,
    PH_KEYIN = 2'd2,
    PH_RUN   = 2'd3
  } phase_e;

  typedef struct packed {
    logic load;    // capture key and nonce
    logic shift;   // advance both registers one step
    logic fbOut;   // xor pre-output into both feedbacks
    logic injKey;  // xor stored key bit into linear feedback
  } strobes_t;

endpackage

// File: rtl/ksgen_filter.sv
module ksgen_filter
  import ksgen_pkg::*;
(
  input  logic [REG_W-1:0] linReg,
  input  logic [REG_W-1:0] nlReg,
  output logic             preOut
);

  logic hVal;
  logic linTap;
  logic nlMask;

  always_comb begin
    // nonlinear filter over mixed taps of both registers
    hVal = (nlReg[12] & linReg[8])
         ^ (linReg[13] & linReg[20])
         ^ (nlReg[95] & linReg[42])
         ^ (linReg[60] & linReg[79])
         ^ (nlReg[12] & nlReg[95] & linReg[94]);
    linTap = linReg[93];
    nlMask = nlReg[2] ^ nlReg[15] ^ nlReg[36] ^ nlReg[45]
           ^ nlReg[64] ^ nlReg[73] ^ nlReg[89];
    preOut = hVal ^ linTap ^ nlMask;
  end

endmodule

// File: rtl/ksgen_datapath.sv
module ksgen_datapath
  import ksgen_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [REG_W-1:0]   keyIn,
  input  logic [NONCE_W-1:0] nonceIn,
  output logic               preOut
);

  localparam int PAD_W = REG_W - NONCE_W;

  logic [REG_W-1:0] linReg;
  logic [REG_W-1:0] nlReg;
  logic [REG_W-1:0] keyStore;
  logic             linFb;
  logic             nlFb;
  logic             linNew;
  logic             nlNew;

  ksgen_filter u_filter (
    .linReg (linReg),
    .nlReg  (nlReg),
    .preOut (preOut)
  );

  always_comb begin
    linFb = linReg[0] ^ linReg[7] ^ linReg[38] ^ linReg[70]
          ^ linReg[81] ^ linReg[96];
    nlFb  = linReg[0] ^ nlReg[0] ^ nlReg[26] ^ nlReg[56] ^ nlReg[91] ^ nlReg[96]
          ^ (nlReg[3]  & nlReg[67])
          ^ (nlReg[11] & nlReg[13])
          ^ (nlReg[17] & nlReg[18])
          ^ (nlReg[27] & nlReg[59])
          ^ (nlReg[40] & nlReg[48])
          ^ (nlReg[61] & nlReg[65])
          ^ (nlReg[68] & nlReg[84])
          ^ (nlReg[22] & nlReg[24] & nlReg[25])
          ^ (nlReg[70] & nlReg[78] & nlReg[82])
          ^ (nlReg[88] & nlReg[92] & nlReg[93] & nlReg[95]);
    linNew = linFb ^ (strb.fbOut & preOut) ^ (strb.injKey & keyStore[0]);
    nlNew  = nlFb  ^ (strb.fbOut & preOut);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linReg   <= '0;
      nlReg    <= '0;
      keyStore <= '0;
    end else if (strb.load) begin
      nlReg    <= keyIn;
      linReg   <= {1'b0, {(PAD_W-1){1'b1}}, nonceIn};
      keyStore <= keyIn;
    end else if (strb.shift) begin
      linReg <= {linNew, linReg[REG_W-1:1]};
      nlReg  <= {nlNew, nlReg[REG_W-1:1]};
      if (strb.injKey) keyStore <= {1'b0, keyStore[REG_W-1:1]};
    end
  end

  // R1: the padding above the nonce is fixed right after a load
  a_r1_load_pad: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (linReg[REG_W-1:NONCE_W] == {1'b0, {(PAD_W-1){1'b1}}}));

  // R7: without load or step the state must not move
  a_r7_hold_state: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> ($stable(linReg) && $stable(nlReg)));

  // R6: key injection and output feedback are never combined
  a_r6_no_mixed_fb: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.fbOut && strb.injKey));

endmodule

// File: rtl/ksgen_ctrl.sv
module ksgen_ctrl
  import ksgen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     enable,
  output strobes_t strb,
  output logic     ready,
  output logic     authPhase,
  output logic     bitValid
);

  localparam int TOTAL = MIX_STEPS + KEY_STEPS;
  localparam int CNT_W = $clog2(TOTAL);

  phase_e           phase;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strb        = '0;
    strb.load   = start;
    strb.fbOut  = !start && (phase == PH_MIX);
    strb.injKey = !start && (phase == PH_KEYIN);
    strb.shift  = !start && ((phase == PH_MIX) || (phase == PH_KEYIN) ||
                             ((phase == PH_RUN) && enable));
    ready       = (phase == PH_RUN);
    authPhase   = (phase == PH_KEYIN);
    bitValid    = ready && enable && !start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      stepCnt <= '0;
    end else if (start) begin
      phase   <= PH_MIX;
      stepCnt <= '0;
    end else begin
      unique case (phase)
        PH_MIX: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(MIX_STEPS - 1)) phase <= PH_KEYIN;
        end
        PH_KEYIN: begin
          if (stepCnt == CNT_W'(TOTAL - 1)) begin
            phase   <= PH_RUN;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R6: the phase flag and ready never overlap
  a_r6_phase_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    !(authPhase && ready));

  // R7: ready only rises straight out of the last re-injection step
  a_r7_ready_after_keyin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(authPhase) && $past(stepCnt) == CNT_W'(TOTAL - 1)));

  // R8: a start clears both flags on the next cycle
  a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!ready && !authPhase));

  // R6: the window opens only after the full mixing count
  a_r6_window_open: assert property (@(posedge clk) disable iff (!rstN)
    $rose(authPhase) |-> ($past(stepCnt) == CNT_W'(MIX_STEPS - 1)));

endmodule

// File: rtl/ksgen_top.sv
module ksgen_top
  import ksgen_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [REG_W-1:0]   keyIn,
  input  logic [NONCE_W-1:0] nonceIn,
  input  logic               enable,
  output logic               bitOut,
  output logic               bitValid,
  output logic               ready,
  output logic               authPhase
);

  strobes_t strb;

  ksgen_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .enable    (enable),
    .strb      (strb),
    .ready     (ready),
    .authPhase (authPhase),
    .bitValid  (bitValid)
  );

  ksgen_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .keyIn   (keyIn),
    .nonceIn (nonceIn),
    .preOut  (bitOut)
  );

  // R7: a valid bit is only offered while ready
  a_r7_valid_in_ready: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (ready && !authPhase));

endmodule

// File: tb/sim_ksgen_top.sv
module sim_ksgen_top;

  localparam time PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [127:0] keyIn = '0;
  logic [95:0]  nonceIn = '0;
  logic         enable = 1'b0;
  logic         bitOut, bitValid, ready, authPhase;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [127:0] mS, mB, mK;

  always #(PERIOD/2) clk = ~clk;

  ksgen_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .keyIn(keyIn), .nonceIn(nonceIn),
    .enable(enable), .bitOut(bitOut), .bitValid(bitValid), .ready(ready),
    .authPhase(authPhase)
  );

  function automatic logic refY(input logic [127:0] s, input logic [127:0] b);
    logic h;
    h = (b[12] & s[8]) ^ (s[13] & s[20]) ^ (b[95] & s[42]) ^ (s[60] & s[79])
      ^ (b[12] & b[95] & s[94]);
    return h ^ s[93] ^ b[2] ^ b[15] ^ b[36] ^ b[45] ^ b[64] ^ b[73] ^ b[89];
  endfunction

  function automatic logic refL(input logic [127:0] s);
    return s[0] ^ s[7] ^ s[38] ^ s[70] ^ s[81] ^ s[96];
  endfunction

  function automatic logic refN(input logic [127:0] s, input logic [127:0] b);
    return s[0] ^ b[0] ^ b[26] ^ b[56] ^ b[91] ^ b[96]
      ^ (b[3] & b[67]) ^ (b[11] & b[13]) ^ (b[17] & b[18]) ^ (b[27] & b[59])
      ^ (b[40] & b[48]) ^ (b[61] & b[65]) ^ (b[68] & b[84])
      ^ (b[22] & b[24] & b[25]) ^ (b[70] & b[78] & b[82])
      ^ (b[88] & b[92] & b[93] & b[95]);
  endfunction

  // mode: 0 plain, 1 output feedback, 2 key injection with bit kb
  task automatic modelStep(input int mode, input logic kb);
    logic y, ln, nn;
    y  = refY(mS, mB);
    ln = refL(mS);
    nn = refN(mS, mB);
    if (mode == 1) begin ln = ln ^ y; nn = nn ^ y; end
    if (mode == 2) ln = ln ^ kb;
    mS = {ln, mS[127:1]};
    mB = {nn, mB[127:1]};
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doStart(input logic [127:0] k, input logic [95:0] n);
    @(negedge clk);
    start = 1'b1; keyIn = k; nonceIn = n;
    @(negedge clk);
    start = 1'b0;
    keyIn = {$urandom, $urandom, $urandom, $urandom};  // port value no longer matters
    mB = k; mK = k;
    mS = {1'b0, {31{1'b1}}, n};
  endtask

  // runs init steps 0..stopAt-1 (stopAt=384 completes)
  task automatic runInit(input int stopAt);
    for (int t = 0; t < stopAt; t++) begin
      enable = 1'($urandom);
      #1;
      if (t == 0) begin
        check("R1 R8 first bit after load", 32'(bitOut), 32'(refY(mS, mB)));
        check("R8 flags cleared", {30'd0, ready, authPhase}, 32'd0);
      end else if (t < 256) begin
        check("R5 mixing bit", 32'(bitOut), 32'(refY(mS, mB)));
      end else begin
        check("R6 reinjection bit", 32'(bitOut), 32'(refY(mS, mB)));
      end
      check(t < 256 ? "R5 flags in mixing" : "R6 flags in reinjection",
            {29'd0, ready, authPhase, bitValid}, {29'd0, 1'b0, (t >= 256), 1'b0});
      @(negedge clk);
      if (t < 256) modelStep(1, 1'b0);
      else begin
        modelStep(2, mK[0]);
        mK = mK >> 1;
      end
    end
  endtask

  task automatic runStream(input int n);
    logic prev;
    for (int i = 0; i < n; i++) begin
      enable = 1'($urandom);
      #1;
      check("R7 ready held", {30'd0, ready, authPhase}, 32'd2);
      check("R7 valid follows enable", 32'(bitValid), 32'(enable));
      check("R2 R3 R4 keystream bit", 32'(bitOut), 32'(refY(mS, mB)));
      prev = bitOut;
      @(negedge clk);
      if (enable) modelStep(0, 1'b0);
      else begin
        #1;
        check("R7 hold when idle", 32'(bitOut), 32'(prev));
      end
    end
    enable = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #(PERIOD * 3);
    enable = 1'b1;
    #1;
    // R9 reset state
    check("R9 reset flags", {29'd0, ready, authPhase, bitValid}, 32'd0);
    check("R9 reset output", 32'(bitOut), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    enable = 1'b0;

    // directed: all zero
    doStart('0, '0);
    runInit(384);
    runStream(200);
    // directed: all ones
    doStart('1, '1);
    runInit(384);
    runStream(150);
    // directed: single key bit, checks injection order
    doStart(128'h1, 96'h0);
    runInit(384);
    runStream(100);
    // abort during mixing
    doStart({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom});
    runInit(100);
    // abort during re-injection
    doStart({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom});
    runInit(300);
    doStart({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom});
    runInit(384);
    runStream(100);
    // random runs
    for (int c = 0; c < 4; c++) begin
      doStart({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom});
      runInit(384);
      runStream(120);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule